// File: doc/BRIEF.md
# Dual-Parallel Quad-SPI Lane Interleaver

This block connects a byte-wide flash controller datapath to two quad-SPI flash devices that share one transfer. In paired mode the two devices act as one 8-bit-wide flash.

Each written data byte is split across the devices. The even-numbered bits go to the lower device and the odd-numbered bits go to the upper device, so one full byte moves per beat. A read rebuilds the byte from the two captured nibbles. A status read collects a whole byte from each device and reports the bitwise OR of the two, so a busy flag from either device appears in the result.

A combined 25-bit byte address is turned into the 24-bit address that both devices receive. Command and address nibbles are sent identically on both lanes.

When the mode input selects a single device, only the lower lane and its select are used. Every byte then takes two beats, with the high nibble sent first.

The controller hands over one item at a time through a valid/ready pair. An item is a command byte, an address, a write byte, a read byte or a status read. The block then produces one beat per clock on the lane outputs. Each lane has its own serial-clock enable, which the pad clock generator uses.

Top module: `qspi_pair_interleave`

## Requirements
- R1: After reset, `req_ready` is high, and `clk_en_lo`, `clk_en_hi`, `oe_lo`, `oe_hi` and `rd_valid` are low.
- R2: A write item (`req_kind` 2) in paired mode takes exactly one beat. In that beat `io_lo_o` = {b6,b4,b2,b0} and `io_hi_o` = {b7,b5,b3,b1}, and both output enables and both clock enables are high.
- R3: A read item (`req_kind` 3) in paired mode takes one beat. The byte is rebuilt with bit 2i taken from `io_lo_i[i]` and bit 2i+1 taken from `io_hi_i[i]`. It appears on `rd_byte`, with `rd_valid` high for exactly one cycle, in the cycle after the beat.
- R4: An address item (`req_kind` 1) sends the 24-bit device address as 6 nibbles, most significant first. The device address is `req_addr[24:1]` in paired mode and `req_addr[23:0]` in single mode. In paired mode the same nibble is sent on both lanes.
- R5: A command item (`req_kind` 0) sends `req_byte` as 2 nibbles, high nibble first. In paired mode the same nibble is sent on both lanes.
- R6: A status item (`req_kind` 4) takes 2 beats. Each lane supplies its own byte, high nibble first. The result is the OR of both lane bytes in paired mode, and the lower byte alone in single mode.
- R7: In single mode (`dual_i` low), `clk_en_hi`, `oe_hi` and `io_hi_o` stay low. Write and read bytes take 2 beats on the lower lane, high nibble first, and `io_hi_i` has no effect.
- R8: `cs_lo_n` is the inverse of `sess_i`. `cs_hi_n` is low only when `sess_i` and `dual_i` are both high.
- R9: `req_ready` is low while an item's beats are in progress. Requests offered during that time have no effect on the beats, and `req_kind` codes 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_i | input | 1 | 1 = paired devices, 0 = single lower device |
| sess_i | input | 1 | Transfer session active (drives selects) |
| req_valid | input | 1 | Item offered |
| req_ready | output | 1 | Block idle and able to take an item |
| req_kind | input | 3 | 0 cmd, 1 addr, 2 write, 3 read, 4 status |
| req_byte | input | 8 | Command or write data byte |
| req_addr | input | 25 | Combined byte address |
| cs_lo_n | output | 1 | Lower device select, active low |
| cs_hi_n | output | 1 | Upper device select, active low |
| clk_en_lo | output | 1 | Lower lane serial clock enable for this beat |
| clk_en_hi | output | 1 | Upper lane serial clock enable for this beat |
| oe_lo | output | 1 | Lower lane output enable |
| oe_hi | output | 1 | Upper lane output enable |
| io_lo_o | output | 4 | Lower lane outgoing nibble |
| io_hi_o | output | 4 | Upper lane outgoing nibble |
| io_lo_i | input | 4 | Lower lane incoming nibble |
| io_hi_i | input | 4 | Upper lane incoming nibble |
| rd_valid | output | 1 | One-cycle strobe, read or status byte ready |
| rd_byte | output | 8 | Read or status result |

## Verification
Write bytes use the patterns 0xFF, 0x55 and 0xAA. An all-even or all-odd pattern shows at once whether the lanes are swapped or the bits are not interleaved.

Read responses use lane nibbles that differ from each other, so a swapped weave or a missing merge gives a wrong byte. Status reads use disjoint bits on the two lanes, which separates an OR from taking either lane alone.

Addresses with bit 0 set and distinct nibbles show whether the drop-LSB translation is applied, and whether nibbles go out in the right order in each mode. Random mixes of items, modes and requests offered while busy cover the rest. In single mode the upper lane input carries garbage, to show that it is ignored.

// File: rtl/qspi_pair_interleave.sv
module qspi_pair_interleave #(
  parameter int DEV_AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_i,
  input  logic              sess_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [7:0]        req_byte,
  input  logic [DEV_AW:0]   req_addr,
  output logic              cs_lo_n,
  output logic              cs_hi_n,
  output logic              clk_en_lo,
  output logic              clk_en_hi,
  output logic              oe_lo,
  output logic              oe_hi,
  output logic [3:0]        io_lo_o,
  output logic [3:0]        io_hi_o,
  input  logic [3:0]        io_lo_i,
  input  logic [3:0]        io_hi_i,
  output logic              rd_valid,
  output logic [7:0]        rd_byte
);
  localparam int NIB = DEV_AW / 4;
  localparam int CW  = $clog2(NIB + 1);
  localparam logic [2:0] K_CMD = 3'd0, K_ADDR = 3'd1, K_WR = 3'd2, K_RD = 3'd3, K_STAT = 3'd4;

  logic              busy;
  logic [2:0]        kind;
  logic [CW-1:0]     left;
  logic [DEV_AW-1:0] sh;
  logic [3:0]        acc_lo, acc_hi;
  logic [7:0]        weave, merged;

  function automatic logic [CW-1:0] beats(input logic [2:0] k, input logic d);
    case (k)
      K_ADDR:     beats = CW'(NIB);
      K_WR, K_RD: beats = d ? CW'(1) : CW'(2);
      default:    beats = CW'(2);
    endcase
  endfunction

  wire take   = req_valid && !busy && (req_kind <= K_STAT);
  wire is_rd  = (kind == K_RD) || (kind == K_STAT);
  wire split  = dual_i && (kind == K_WR);
  wire [3:0] top = sh[DEV_AW-1 -: 4];
  wire [7:0] tb  = sh[DEV_AW-1 -: 8];
  wire [DEV_AW-1:0] dev_addr = dual_i ? req_addr[DEV_AW:1] : req_addr[DEV_AW-1:0];
  wire [DEV_AW-1:0] load = (req_kind == K_ADDR) ? dev_addr : {req_byte, {(DEV_AW-8){1'b0}}};

  assign req_ready = !busy;
  assign cs_lo_n   = !sess_i;
  assign cs_hi_n   = !(sess_i && dual_i);
  assign clk_en_lo = busy;
  assign clk_en_hi = busy && dual_i;
  assign oe_lo     = busy && !is_rd;
  assign oe_hi     = oe_lo && dual_i;
  assign io_lo_o   = !oe_lo ? 4'h0 : split ? {tb[6], tb[4], tb[2], tb[0]} : top;
  assign io_hi_o   = !oe_hi ? 4'h0 : split ? {tb[7], tb[5], tb[3], tb[1]} : top;

  for (genvar i = 0; i < 4; i++) begin : g_weave
    assign weave[2*i]   = io_lo_i[i];
    assign weave[2*i+1] = io_hi_i[i];
  end

  wire [7:0] byte_lo = {acc_lo, io_lo_i};
  wire [7:0] byte_hi = {acc_hi, io_hi_i};
  assign merged = (kind == K_STAT) ? (dual_i ? (byte_lo | byte_hi) : byte_lo)
                                   : (dual_i ? weave : byte_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      kind     <= K_CMD;
      left     <= '0;
      sh       <= '0;
      acc_lo   <= '0;
      acc_hi   <= '0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (busy) begin
        sh     <= sh << 4;
        left   <= left - CW'(1);
        acc_lo <= io_lo_i;
        acc_hi <= io_hi_i;
        if (left == CW'(1)) begin
          busy <= 1'b0;
          if (is_rd) begin
            rd_valid <= 1'b1;
            rd_byte  <= merged;
          end
        end
      end else if (take) begin
        busy <= 1'b1;
        kind <= req_kind;
        left <= beats(req_kind, dual_i);
        sh   <= load;
      end
    end
  end
endmodule

module qspi_pair_interleave_chk (
  input logic clk,
  input logic rst_n,
  input logic dual_i,
  input logic req_ready,
  input logic cs_lo_n,
  input logic cs_hi_n,
  input logic clk_en_lo,
  input logic clk_en_hi,
  input logic oe_lo,
  input logic oe_hi,
  input logic rd_valid
);
  a_r7_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_i |-> (!clk_en_hi && !oe_hi));
  a_r8_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_hi_n |-> !cs_lo_n);
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_lo |-> !req_ready);
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r3_valid_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(clk_en_lo));
  a_r2_enables_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_i && oe_lo) |-> (oe_hi && clk_en_hi));
endmodule

bind qspi_pair_interleave qspi_pair_interleave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dual_i(dual_i), .req_ready(req_ready),
  .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n), .clk_en_lo(clk_en_lo), .clk_en_hi(clk_en_hi),
  .oe_lo(oe_lo), .oe_hi(oe_hi), .rd_valid(rd_valid)
);

// File: tb/qspi_pair_interleave_test.sv
module qspi_pair_interleave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual = 1'b1, sess = 1'b0, req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [7:0] req_byte = 8'h00;
  logic [24:0] req_addr = '0;
  logic [3:0] io_lo_i = 4'h0, io_hi_i = 4'h0;
  logic req_ready, cs_lo_n, cs_hi_n, clk_en_lo, clk_en_hi, oe_lo, oe_hi, rd_valid;
  logic [3:0] io_lo_o, io_hi_o;
  logic [7:0] rd_byte;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qspi_pair_interleave uut (
    .clk(clk), .rst_n(rst_n), .dual_i(dual), .sess_i(sess),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_byte(req_byte), .req_addr(req_addr), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
    .clk_en_lo(clk_en_lo), .clk_en_hi(clk_en_hi), .oe_lo(oe_lo), .oe_hi(oe_hi),
    .io_lo_o(io_lo_o), .io_hi_o(io_hi_o), .io_lo_i(io_lo_i), .io_hi_i(io_hi_i),
    .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbeats(input int k, input bit d);
    if (k == 1) return 6;
    if ((k == 2 || k == 3) && d) return 1;
    return 2;
  endfunction

  function automatic string tagof(input int k, input bit d);
    case (k)
      0: return "R5";
      1: return "R4";
      2: return d ? "R2" : "R7";
      3: return d ? "R3" : "R7";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [3:0] exp_lo(input int k, input bit d, input logic [7:0] b,
                                        input logic [24:0] a, input int n);
    logic [23:0] dev;
    dev = d ? a[24:1] : a[23:0];
    if (k == 3 || k == 4) return 4'h0;
    if (k == 1) return dev[23-4*n -: 4];
    if (k == 2 && d) return {b[6], b[4], b[2], b[0]};
    return (n == 0) ? b[7:4] : b[3:0];
  endfunction

  function automatic logic [3:0] exp_hi(input int k, input bit d, input logic [7:0] b,
                                        input logic [24:0] a, input int n);
    if (!d || k == 3 || k == 4) return 4'h0;
    if (k == 2) return {b[7], b[5], b[3], b[1]};
    return exp_lo(k, d, b, a, n);
  endfunction

  function automatic logic [7:0] exp_res(input int k, input bit d, input logic [7:0] rl,
                                         input logic [7:0] rh);
    logic [7:0] w;
    if (k == 4) return d ? (rl | rh) : rl;
    if (!d) return rl;
    for (int i = 0; i < 4; i++) begin
      w[2*i] = rl[i];
      w[2*i+1] = rh[i];
    end
    return w;
  endfunction

  task automatic run(input int k, input bit d, input logic [7:0] b, input logic [24:0] a,
                     input logic [7:0] rl, input logic [7:0] rh, input bit junk);
    string tag;
    int n;
    bit rd;
    tag = tagof(k, d);
    n = nbeats(k, d);
    rd = (k == 3 || k == 4);
    @(negedge clk);
    dual = d; req_valid = 1'b1; req_kind = 3'(k); req_byte = b; req_addr = a;
    @(posedge clk);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (junk) begin
        req_valid = (j < n - 1); req_kind = 3'd2; req_byte = ~b; req_addr = ~a;
      end else req_valid = 1'b0;
      if (rd) begin
        if (k == 3 && d) begin
          io_lo_i = rl[3:0]; io_hi_i = rh[3:0];
        end else begin
          io_lo_i = (j == 0) ? rl[7:4] : rl[3:0];
          io_hi_i = d ? ((j == 0) ? rh[7:4] : rh[3:0]) : 4'($urandom);
        end
      end else begin
        io_lo_i = 4'($urandom); io_hi_i = 4'($urandom);
      end
      check(junk ? {tag, " R9"} : tag,
            {20'h0, req_ready, clk_en_lo, clk_en_hi, oe_lo, oe_hi, 3'b0, io_lo_o, io_hi_o},
            {20'h0, 1'b0, 1'b1, d, !rd, !rd && d, 3'b0, exp_lo(k, d, b, a, j), exp_hi(k, d, b, a, j)});
      @(posedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " end"}, {29'h0, clk_en_lo, req_ready, rd_valid}, {29'h0, 1'b0, 1'b1, rd});
    if (rd) begin
      check({tag, " data"}, {24'h0, rd_byte}, {24'h0, exp_res(k, d, rl, rh)});
      @(negedge clk);
      check({tag, " pulse"}, {31'h0, rd_valid}, 32'h0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset", {26'h0, req_ready, clk_en_lo, clk_en_hi, oe_lo, oe_hi, rd_valid}, {26'h0, 6'b100000});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", {26'h0, req_ready, clk_en_lo, clk_en_hi, oe_lo, oe_hi, rd_valid}, {26'h0, 6'b100000});
    for (int c = 0; c < 4; c++) begin
      sess = c[0]; dual = c[1];
      #1;
      check("R8 selects", {30'h0, cs_lo_n, cs_hi_n}, {30'h0, !c[0], !(c[0] && c[1])});
    end
    sess = 1'b1;
    run(0, 1, 8'hA5, 25'h0, 8'h0, 8'h0, 0);
    run(1, 1, 8'h00, 25'h1ABCDEF, 8'h0, 8'h0, 0);
    run(1, 0, 8'h00, 25'h1ABCDEF, 8'h0, 8'h0, 0);
    run(2, 1, 8'hFF, 25'h0, 8'h0, 8'h0, 0);
    run(2, 1, 8'h55, 25'h0, 8'h0, 8'h0, 0);
    run(2, 1, 8'hAA, 25'h0, 8'h0, 8'h0, 0);
    run(2, 0, 8'h3C, 25'h0, 8'h0, 8'h0, 0);
    run(3, 1, 8'h00, 25'h0, 8'h0C, 8'h05, 0);
    run(3, 0, 8'h00, 25'h0, 8'hC5, 8'hFF, 0);
    run(4, 1, 8'h00, 25'h0, 8'h01, 8'h80, 0);
    run(4, 0, 8'h00, 25'h0, 8'h01, 8'h80, 0);
    run(1, 1, 8'h00, 25'h0123457, 8'h0, 8'h0, 1);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd6;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 bad kind", {30'h0, clk_en_lo, req_ready}, {30'h0, 2'b01});
    for (int r = 0; r < 400; r++)
      run(int'($urandom_range(0, 4)), bit'($urandom), 8'($urandom), 25'($urandom),
          8'($urandom), 8'($urandom), bit'($urandom));
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule